// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The controller watches a bank of asynchronous input lines and turns their level changes into interrupt activity. Each line is brought into the clock domain by a two-stage synchronizer. Each line then has its own edge detector, its own sticky pending flag and its own interrupt output. For each line, software picks which edge directions set the pending flag and whether the line's interrupt output is enabled.

Software reaches six 32-bit registers through a simple synchronous port with an address, a write strobe, write data and combinational read data. Five registers are plain storage: interrupt enable, event enable, rising select, falling select and software trigger. The sixth holds the pending flags. Writing a one to a pending bit clears it. The interrupt enable only gates the output pulse and never stops a pending flag from latching. The number of lines is a parameter of up to 32, and register bits above that count read as zero.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all six registers read 0x0000_0000 and every interrupt output is low.
- R2: When a line goes from low to high and its bit in the rising-select register (offset 0x08) is 1, its bit in the pending register (offset 0x14) becomes 1. This includes the highest line, bit NLINES-1.
- R3: When a line goes from high to low and its bit in the falling-select register (offset 0x0C) is 1, its pending bit becomes 1.
- R4: An edge whose direction is not selected for that line leaves the line's pending bit unchanged.
- R5: A pending bit latches even when the line's bit in the interrupt-enable register (offset 0x00) is 0.
- R6: A write to the pending register clears each bit written as 1. Bits written as 0 keep their value. Such a write never sets a bit.
- R7: When a line's interrupt-enable bit is 1, each level change on the line, in either direction and whether selected or not, gives a pulse exactly one cycle wide on that line's output. The pulse is high between the third and fourth rising clock edges after the input changes. When the enable bit is 0, no pulse appears.
- R8: The interrupt-enable (0x00), event-enable (0x04), rising-select (0x08), falling-select (0x0C) and software-trigger (0x10) registers read back what was written. Bits NLINES and above read as 0 (NLINES = 16 by default).
- R9: Only the six exact byte offsets listed above are mapped inside the 0x400-byte window. A read from any other offset returns 0, and a write to any other offset changes no register.
- R10: If a selected edge and a write of 1 reach the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | NLINES | Asynchronous external input lines |
| bus_addr | input | 10 | Byte offset into the register window |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NLINES | Per-line interrupt pulses |

## Verification
The bench goes after the cases where a simple design goes wrong.

- **Masked lines.** The bench toggles lines whose enable is off. A design that gated the pending flag with the enable would lose these events.
- **Unselected edges.** It drives edges in the direction that was not selected. A design that set the flag on any change would fail here.
- **Pending writes of 0.** It writes zeros to set pending bits. A plain read/write pending register would wipe them.
- **Clear colliding with an edge.** It times a write-one-to-clear onto the same cycle as a new edge. A clear-first priority would drop that edge.
- **Pulse width and timing.** It samples the interrupt output in its one high cycle and in the cycle after. This catches a level output and a shifted synchronizer depth.
- **Upper bits and bad offsets.** It checks that the upper register bits read zero, and that unaligned and unmapped offsets neither read nor write state.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 10;

    localparam logic [ADDR_W-1:0] OFF_IEN  = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_EVEN = 10'h004;
    localparam logic [ADDR_W-1:0] OFF_RISE = 10'h008;
    localparam logic [ADDR_W-1:0] OFF_FALL = 10'h00C;
    localparam logic [ADDR_W-1:0] OFF_SWT  = 10'h010;
    localparam logic [ADDR_W-1:0] OFF_PEND = 10'h014;

    typedef enum logic [2:0] {
        SEL_IEN,
        SEL_EVEN,
        SEL_RISE,
        SEL_FALL,
        SEL_SWT,
        SEL_PEND,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_IEN:  s = SEL_IEN;
            OFF_EVEN: s = SEL_EVEN;
            OFF_RISE: s = SEL_RISE;
            OFF_FALL: s = SEL_FALL;
            OFF_SWT:  s = SEL_SWT;
            OFF_PEND: s = SEL_PEND;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_i,
    output logic [NLINES-1:0] rise_o,
    output logic [NLINES-1:0] fall_o
);

    typedef struct packed {
        logic [NLINES-1:0] meta;
        logic [NLINES-1:0] sync;
        logic [NLINES-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = line_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_edge
        assign rise_o[i] =  st_q.sync[i] & ~st_q.prev[i];
        assign fall_o[i] = ~st_q.sync[i] &  st_q.prev[i];
    end

    // An edge must come from a real change seen two stages earlier
    AST_EDGE_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((rise_o | fall_o) & ~($past(st_q.meta) ^ $past(st_q.sync))) == '0)); // R7

endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  reg_sel_e          sel_i,
    input  logic [NLINES-1:0] wbits_i,
    input  logic [NLINES-1:0] rise_i,
    input  logic [NLINES-1:0] fall_i,
    output logic [NLINES-1:0] ien_o,
    output logic [NLINES-1:0] even_o,
    output logic [NLINES-1:0] rsel_o,
    output logic [NLINES-1:0] fsel_o,
    output logic [NLINES-1:0] swt_o,
    output logic [NLINES-1:0] pend_o,
    output logic [NLINES-1:0] irq_o
);

    typedef struct packed {
        logic [NLINES-1:0] ien;
        logic [NLINES-1:0] even;
        logic [NLINES-1:0] rsel;
        logic [NLINES-1:0] fsel;
        logic [NLINES-1:0] swt;
        logic [NLINES-1:0] pend;
        logic [NLINES-1:0] irq;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [NLINES-1:0] clr_mask;
    logic [NLINES-1:0] hit;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (we_i) begin
            case (sel_i)
                SEL_IEN:  st_d.ien  = wbits_i;
                SEL_EVEN: st_d.even = wbits_i;
                SEL_RISE: st_d.rsel = wbits_i;
                SEL_FALL: st_d.fsel = wbits_i;
                SEL_SWT:  st_d.swt  = wbits_i;
                SEL_PEND: clr_mask  = wbits_i;
                default:  ;
            endcase
        end
        hit       = (rise_i & st_q.rsel) | (fall_i & st_q.fsel);
        st_d.pend = (st_q.pend & ~clr_mask) | hit;
        st_d.irq  = (rise_i | fall_i) & st_q.ien;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ien_o  = st_q.ien;
    assign even_o = st_q.even;
    assign rsel_o = st_q.rsel;
    assign fsel_o = st_q.fsel;
    assign swt_o  = st_q.swt;
    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;

    AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_i & st_q.rsel) != '0) |=> ((st_q.pend & $past(rise_i & st_q.rsel)) == $past(rise_i & st_q.rsel))); // R2
    AST_FALL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall_i & st_q.fsel) != '0) |=> ((st_q.pend & $past(fall_i & st_q.fsel)) == $past(fall_i & st_q.fsel))); // R3
    AST_NO_SET_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend) & ~$past(rise_i | fall_i)) == '0)); // R4
    AST_CLEAR_ONLY_BY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.pend) & ~st_q.pend & ~$past((we_i && sel_i == SEL_PEND) ? wbits_i : '0)) == '0)); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.irq & ~$past(st_q.ien)) == '0)); // R7

endmodule

// File: rtl/eic_rdmux.sv
module eic_rdmux
    import eic_pkg::*;
#(
    parameter int NLINES = 16
) (
    input  reg_sel_e              sel_i,
    input  logic [NLINES-1:0]     ien_i,
    input  logic [NLINES-1:0]     even_i,
    input  logic [NLINES-1:0]     rsel_i,
    input  logic [NLINES-1:0]     fsel_i,
    input  logic [NLINES-1:0]     swt_i,
    input  logic [NLINES-1:0]     pend_i,
    output logic [DATA_W-1:0]     rdata_o
);

    logic [NLINES-1:0] pick;

    always_comb begin
        case (sel_i)
            SEL_IEN:  pick = ien_i;
            SEL_EVEN: pick = even_i;
            SEL_RISE: pick = rsel_i;
            SEL_FALL: pick = fsel_i;
            SEL_SWT:  pick = swt_i;
            SEL_PEND: pick = pend_i;
            default:  pick = '0;
        endcase
        rdata_o              = '0;
        rdata_o[NLINES-1:0]  = pick;
    end

    always_comb begin
        if (sel_i == SEL_NONE)
            AST_UNMAPPED_ZERO: assert (rdata_o == '0); // R9
    end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NLINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLINES-1:0]    line_i,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NLINES-1:0]    irq_o
);

    reg_sel_e          sel;
    logic [NLINES-1:0] rise, fall;
    logic [NLINES-1:0] ien, even, rsel, fsel, swt, pend;
    logic              unused_wbits;

    assign sel          = decode_addr(bus_addr);
    assign unused_wbits = ^bus_wdata;

    eic_sync #(.NLINES(NLINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    eic_regs #(.NLINES(NLINES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .sel_i   (sel),
        .wbits_i (bus_wdata[NLINES-1:0]),
        .rise_i  (rise),
        .fall_i  (fall),
        .ien_o   (ien),
        .even_o  (even),
        .rsel_o  (rsel),
        .fsel_o  (fsel),
        .swt_o   (swt),
        .pend_o  (pend),
        .irq_o   (irq_o)
    );

    eic_rdmux #(.NLINES(NLINES)) u_rdmux (
        .sel_i   (sel),
        .ien_i   (ien),
        .even_i  (even),
        .rsel_i  (rsel),
        .fsel_i  (fsel),
        .swt_i   (swt),
        .pend_i  (pend),
        .rdata_o (bus_rdata)
    );

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_NONE) |=> $stable({ien, even, rsel, fsel, swt})); // R9

endmodule

// File: tb/edge_irq_ctrl_tb.sv
`timescale 1ns/1ps
module edge_irq_ctrl_tb;

    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lines = '0;
    logic [9:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  mon_vld = 1'b0;
    bit  done    = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    edge_irq_ctrl #(.NLINES(NL)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (lines),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // monitor: pops expected items and compares away from the clock edge
    always @(negedge clk) begin
        #1;
        if (mon_vld && sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? 32'(irq_o) : bus_rdata;
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk(input bit irq, input logic [9:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        sb_q.push_back('{irq, e, tag});
        mon_vld = 1'b1;
        #2;
        mon_vld = 1'b0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic setl(input int idx, input logic v);
        @(negedge clk);
        lines[idx] = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < 6; k++) chk(0, 10'(k * 4), 32'h0, "R1 reset reg");
        chk(1, 10'h000, 32'h0, "R1 reset irq");

        // R8 plain registers, upper bits zero
        for (int k = 0; k < 5; k++) begin
            wr(10'(k * 4), 32'hFFFF_FFFF);
            chk(0, 10'(k * 4), 32'h0000_FFFF, "R8 all ones");
            wr(10'(k * 4), 32'h1234_A5C3);
            chk(0, 10'(k * 4), 32'h0000_A5C3, "R8 pattern");
            wr(10'(k * 4), 32'h0);
        end

        // R9 unmapped offsets
        wr(10'h018, 32'hFFFF_FFFF);
        wr(10'h001, 32'hFFFF_FFFF);
        wr(10'h3FC, 32'hFFFF_FFFF);
        chk(0, 10'h000, 32'h0, "R9 unaligned write ignored");
        chk(0, 10'h004, 32'h0, "R9 unmapped write ignored");
        chk(0, 10'h018, 32'h0, "R9 unmapped read");
        chk(0, 10'h3FC, 32'h0, "R9 top of window read");
        chk(0, 10'h002, 32'h0, "R9 unaligned read");

        // R2 / R5 rising edge, line masked
        wr(10'h008, 32'h0000_0001);
        setl(0, 1'b1);
        repeat (2) @(negedge clk);
        chk(1, 10'h000, 32'h0, "R7 masked no pulse");
        settle();
        chk(0, 10'h014, 32'h0000_0001, "R2 R5 rise latched while masked");

        // R4 rise on unselected line
        setl(1, 1'b1);
        settle();
        chk(0, 10'h014, 32'h0000_0001, "R4 unselected rise");

        // R6 write-one-to-clear
        wr(10'h014, 32'h0);
        chk(0, 10'h014, 32'h0000_0001, "R6 zero write keeps");
        wr(10'h014, 32'h0000_0002);
        chk(0, 10'h014, 32'h0000_0001, "R6 other bit write keeps");
        wr(10'h014, 32'h0000_0001);
        chk(0, 10'h014, 32'h0, "R6 one clears");

        // R3 falling edge, R4 unselected fall
        wr(10'h00C, 32'h0000_0002);
        setl(1, 1'b0);
        settle();
        chk(0, 10'h014, 32'h0000_0002, "R3 fall latched");
        setl(0, 1'b0);
        settle();
        chk(0, 10'h014, 32'h0000_0002, "R4 unselected fall");

        // R7 pulses on enabled line, both directions
        wr(10'h000, 32'h0000_0004);
        setl(2, 1'b1);
        repeat (2) @(negedge clk);
        chk(1, 10'h000, 32'h0000_0004, "R7 rise pulse high");
        chk(1, 10'h000, 32'h0, "R7 rise pulse one cycle");
        setl(2, 1'b0);
        repeat (2) @(negedge clk);
        chk(1, 10'h000, 32'h0000_0004, "R7 fall pulse high");
        chk(1, 10'h000, 32'h0, "R7 fall pulse one cycle");
        chk(0, 10'h014, 32'h0000_0002, "R4 pulse without select");

        // R10 set wins over same-cycle clear
        wr(10'h008, 32'h0000_0009);
        setl(3, 1'b1);
        @(negedge clk);
        wr(10'h014, 32'h0000_000A);
        chk(0, 10'h014, 32'h0000_0008, "R10 set beats clear");

        // R2 top line
        wr(10'h008, 32'h0000_8000);
        setl(15, 1'b1);
        settle();
        chk(0, 10'h014, 32'h0000_8008, "R2 highest line");
        wr(10'h014, 32'hFFFF_FFFF);
        chk(0, 10'h014, 32'h0, "R6 clear all");

        settle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule